// File: doc/BRIEF.md
# Single-Precision Float Classify Unit

This execution unit sorts a single-precision floating-point operand into exactly one of ten classes and hands back a one-hot class code as an integer result. It receives the instruction word, the contents of the floating-point source register and an enable flag for the floating-point unit. From the instruction word it pulls out the source floating-point register index and the destination integer register index. Only the low 32 bits of the source register are inspected. The class code is zero-extended to the integer width and returned with a write enable for the destination register.

When the floating-point unit is switched off, the unit does not write the destination register. It reports an illegal-instruction condition instead. The unit never reports floating-point exception flags, including for signaling NaNs. No privilege input exists, so the privilege level cannot cause a trap. Requests and responses each use a valid/ready handshake. A single output register holds each result, which appears one cycle after its request is accepted.

Top module: `sp_class_unit`

## Requirements
- R1: The class code sits in result bits [9:0]. Bit 0 is negative infinity, bit 1 negative normal, bit 2 negative subnormal, bit 3 negative zero, bit 4 positive zero, bit 5 positive subnormal, bit 6 positive normal, bit 7 positive infinity, bit 8 signaling NaN and bit 9 quiet NaN. Operand bits above bit 31 have no effect on the result.
- R2: For every legal result, exactly one of bits [9:0] is set, and every result bit from 10 up to XLEN-1 is zero.
- R3: Decoding uses the sign (bit 31), the exponent (bits [30:23]) and the fraction (bits [22:0]), as follows.
  - Exponent 0xFF with a zero fraction is infinity.
  - Exponent 0xFF with a nonzero fraction is a NaN. It is quiet when fraction bit 22 is set and signaling when that bit is clear. The sign of a NaN is ignored.
  - Exponent 0 with a zero fraction is zero, and exponent 0 with a nonzero fraction is subnormal.
  - Any other exponent is normal.
- R4: The response carries the source index from instruction bits [19:15] on rspRs and the destination index from bits [11:7] on rspRd.
- R5: rspFlags (five accrued exception flag bits) is zero in every response, including responses for signaling NaNs.
- R6: A request accepted with fpEnable low gives a response with rspIllegal=1, rspWrEn=0 and rspData=0. With fpEnable high, the response has rspIllegal=0 and rspWrEn=1.
- R7: rspValid rises in the cycle after a request is accepted. rspValid is 0 after reset.
- R8: reqReady equals (!rspValid || rspReady). While rspValid is high and rspReady is low, every response output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Unit can take a request this cycle |
| instrWord | input | 32 | Instruction word |
| fpOperand | input | FLEN | Floating-point source register contents |
| fpEnable | input | 1 | Floating-point unit enabled |
| rspValid | output | 1 | Response present |
| rspReady | input | 1 | Consumer takes the response |
| rspData | output | XLEN | Zero-extended class code |
| rspRd | output | 5 | Destination integer register index |
| rspRs | output | 5 | Source floating-point register index |
| rspWrEn | output | 1 | Destination register write enable |
| rspIllegal | output | 1 | Illegal-instruction indication |
| rspFlags | output | 5 | Accrued exception flags (always zero) |

## Verification
The assertions check the following on every cycle:
- the one-hot shape of each legal result and the zero upper bits;
- that write enable and illegal never occur together and that an illegal response carries zero data;
- that accepting a request leads to a valid response one cycle later;
- that ready follows the drain rule;
- that a stalled response holds still.

Some properties can only be shown by the bench's scenarios, with the reference classifier and scoreboard:
- that each operand lands in the correct class, including the boundary encodings (smallest and largest normals, largest subnormal, NaNs of either sign and either quiet bit);
- that upper operand bits and privilege play no part;
- that the register indices come from the correct instruction fields.

// File: rtl/sp_class_pkg.sv
package sp_class_pkg;
  localparam int CLASS_W = 10;
  localparam int IDX_W   = 5;
  localparam int FLAG_W  = 5;
  localparam int SP_W    = 32;

  // Magnitude-ordered class index used per sign half
  typedef enum int unsigned {
    MAG_ZERO = 0,
    MAG_SUB  = 1,
    MAG_NORM = 2,
    MAG_INF  = 3
  } magClass_e;

  localparam int MAG_N = 4;

  typedef struct packed {
    logic load;
    logic drop;
  } ctrlStrobe_t;
endpackage

// File: rtl/sp_class_ctrl.sv
module sp_class_ctrl
  import sp_class_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        rspReady,
  output logic        reqReady,
  output logic        rspValid,
  output ctrlStrobe_t strobe
);
  logic outValidQ;

  assign reqReady    = !outValidQ || rspReady;
  assign strobe.load = reqValid && reqReady;
  assign strobe.drop = outValidQ && rspReady && !strobe.load;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValidQ <= 1'b0;
    end else if (strobe.load) begin
      outValidQ <= 1'b1;
    end else if (strobe.drop) begin
      outValidQ <= 1'b0;
    end
  end

  assign rspValid = outValidQ;
endmodule

// File: rtl/sp_class_datapath.sv
module sp_class_datapath
  import sp_class_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int FLEN = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [31:0]       instrWord,
  input  logic [FLEN-1:0]   fpOperand,
  input  logic              fpEnable,
  output logic [XLEN-1:0]   rspData,
  output logic [IDX_W-1:0]  rspRd,
  output logic [IDX_W-1:0]  rspRs,
  output logic              rspWrEn,
  output logic              rspIllegal,
  output logic [FLAG_W-1:0] rspFlags
);
  localparam int PAD_W = XLEN - CLASS_W;

  logic [SP_W-1:0] spVal;
  logic            signBit;
  logic [7:0]      expField;
  logic [22:0]     fracField;
  logic            expAllOnes;
  logic            expAllZero;
  logic            fracZero;
  logic [MAG_N-1:0] magHit;
  logic [CLASS_W-1:0] classMask;
  logic [XLEN-1:0]  resultNext;

  assign spVal      = fpOperand[SP_W-1:0];
  assign signBit    = spVal[31];
  assign expField   = spVal[30:23];
  assign fracField  = spVal[22:0];
  assign expAllOnes = &expField;
  assign expAllZero = ~|expField;
  assign fracZero   = ~|fracField;

  // Sign-independent magnitude class
  assign magHit[MAG_ZERO] = expAllZero && fracZero;
  assign magHit[MAG_SUB]  = expAllZero && !fracZero;
  assign magHit[MAG_NORM] = !expAllZero && !expAllOnes;
  assign magHit[MAG_INF]  = expAllOnes && fracZero;

  // Negative half counts down from bit 3, positive half counts up from bit 4
  genvar k;
  generate
    for (k = 0; k < MAG_N; k++) begin : g_mag
      assign classMask[MAG_N-1-k] = magHit[k] && signBit;
      assign classMask[MAG_N+k]   = magHit[k] && !signBit;
    end
  endgenerate

  assign classMask[8] = expAllOnes && !fracZero && !fracField[22];
  assign classMask[9] = expAllOnes && fracField[22];

  generate
    if (PAD_W > 0) begin : g_pad
      assign resultNext = {{PAD_W{1'b0}}, classMask};
    end else begin : g_nopad
      assign resultNext = classMask[XLEN-1:0];
    end
  endgenerate

  // Operand and instruction bits outside the decoded fields
  generate
    if (FLEN > SP_W) begin : g_hiop
      logic unusedHi;
      assign unusedHi = ^fpOperand[FLEN-1:SP_W];
    end
  endgenerate
  logic unusedInstr;
  assign unusedInstr = ^{instrWord[31:20], instrWord[14:12], instrWord[6:0]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspData    <= '0;
      rspRd      <= '0;
      rspRs      <= '0;
      rspWrEn    <= 1'b0;
      rspIllegal <= 1'b0;
      rspFlags   <= '0;
    end else if (strobe.load) begin
      rspData    <= fpEnable ? resultNext : '0;
      rspRd      <= instrWord[11:7];
      rspRs      <= instrWord[19:15];
      rspWrEn    <= fpEnable;
      rspIllegal <= !fpEnable;
      rspFlags   <= '0;
    end
  end
endmodule

// File: rtl/sp_class_unit.sv
module sp_class_unit
  import sp_class_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int FLEN = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [31:0]       instrWord,
  input  logic [FLEN-1:0]   fpOperand,
  input  logic              fpEnable,
  output logic              rspValid,
  input  logic              rspReady,
  output logic [XLEN-1:0]   rspData,
  output logic [4:0]        rspRd,
  output logic [4:0]        rspRs,
  output logic              rspWrEn,
  output logic              rspIllegal,
  output logic [4:0]        rspFlags
);
  ctrlStrobe_t strobe;

  sp_class_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .rspReady (rspReady),
    .reqReady (reqReady),
    .rspValid (rspValid),
    .strobe   (strobe)
  );

  sp_class_datapath #(.XLEN(XLEN), .FLEN(FLEN)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .instrWord  (instrWord),
    .fpOperand  (fpOperand),
    .fpEnable   (fpEnable),
    .rspData    (rspData),
    .rspRd      (rspRd),
    .rspRs      (rspRs),
    .rspWrEn    (rspWrEn),
    .rspIllegal (rspIllegal),
    .rspFlags   (rspFlags)
  );
endmodule

// File: rtl/sp_class_unit_chk.sv
module sp_class_unit_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rstN,
  input logic            reqValid,
  input logic            reqReady,
  input logic            rspValid,
  input logic            rspReady,
  input logic [XLEN-1:0] rspData,
  input logic [4:0]      rspRd,
  input logic            rspWrEn,
  input logic            rspIllegal
);
  // R2
  onehot_class_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspWrEn) |-> ($countones(rspData[9:0]) == 1));

  // R2
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> ((rspData >> 10) == '0));

  // R6
  illegal_nowrite_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspIllegal) |-> (!rspWrEn && rspData == '0));

  // R6
  wr_xor_illegal_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (rspWrEn != rspIllegal));

  // R7
  accept_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> rspValid);

  // R8
  ready_rule_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqReady == (!rspValid || rspReady));

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |=> (rspValid && $stable(rspData) && $stable(rspRd)
                                 && $stable(rspWrEn)));
endmodule

bind sp_class_unit sp_class_unit_chk #(.XLEN(XLEN)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .reqReady   (reqReady),
  .rspValid   (rspValid),
  .rspReady   (rspReady),
  .rspData    (rspData),
  .rspRd      (rspRd),
  .rspWrEn    (rspWrEn),
  .rspIllegal (rspIllegal)
);

// File: tb/sp_class_unit_tb_top.sv
`timescale 1ns/1ps
module sp_class_unit_tb_top;
  localparam int XLEN = 64;
  localparam int FLEN = 64;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            reqValid = 1'b0;
  logic            reqReady;
  logic [31:0]     instrWord = '0;
  logic [FLEN-1:0] fpOperand = '0;
  logic            fpEnable = 1'b0;
  logic            rspValid;
  logic            rspReady = 1'b1;
  logic [XLEN-1:0] rspData;
  logic [4:0]      rspRd;
  logic [4:0]      rspRs;
  logic            rspWrEn;
  logic            rspIllegal;
  logic [4:0]      rspFlags;

  always #2.5 clk = ~clk;

  sp_class_unit #(.XLEN(XLEN), .FLEN(FLEN)) dut_i (.*);

  typedef struct {
    logic [XLEN-1:0] data;
    logic [4:0]      rd;
    logic [4:0]      rs;
    logic            wrEn;
    logic            illegal;
    string           tag;
  } expItem_t;

  expItem_t expQ[$];
  int  checks = 0;
  int  fails  = 0;
  bit  stallMode = 1'b0;
  bit  finished = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [63:0] got,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [9:0] refMask(input logic [31:0] v);
    logic [7:0]  e;
    logic [22:0] f;
    e = v[30:23];
    f = v[22:0];
    if (e == 8'hFF) begin
      if (f == 0) return v[31] ? 10'h001 : 10'h080;
      return f[22] ? 10'h200 : 10'h100;
    end
    if (e == 8'h00) begin
      if (f == 0) return v[31] ? 10'h008 : 10'h010;
      return v[31] ? 10'h004 : 10'h020;
    end
    return v[31] ? 10'h002 : 10'h040;
  endfunction

  task automatic sendReq(input logic [31:0] op, input logic [31:0] hi,
                         input logic en, input logic [4:0] rs,
                         input logic [4:0] rd, input string tag);
    expItem_t it;
    bit acc;
    @(negedge clk);
    instrWord = {12'h00F, rs, 3'b001, rd, 7'b1010011} ^ {12'hA5A, 5'd0, 3'b110, 5'd0, 7'd0};
    fpOperand = {hi, op};
    fpEnable  = en;
    reqValid  = 1'b1;
    it.data    = en ? {54'd0, refMask(op)} : '0;
    it.rd      = rd;
    it.rs      = rs;
    it.wrEn    = en;
    it.illegal = !en;
    it.tag     = tag;
    expQ.push_back(it);
    forever begin
      #2;
      acc = reqReady;
      @(posedge clk);
      @(negedge clk);
      if (acc) break;
    end
    reqValid = 1'b0;
    #2;
    // R7: response present one cycle after acceptance
    check(rspValid === 1'b1, "R7 latency", {63'd0, rspValid}, 64'd1);
  endtask

  // Consumer ready pattern
  initial begin
    forever begin
      @(negedge clk);
      rspReady = stallMode ? ($urandom_range(0, 2) != 0) : 1'b1;
    end
  end

  // Monitor / scoreboard
  initial begin
    logic [XLEN-1:0] heldData;
    bit wasStall;
    wasStall = 1'b0;
    heldData = '0;
    forever begin
      @(negedge clk);
      #1;
      if (rstN) begin
        // R8: ready rule seen at the ports
        if (reqReady !== (!rspValid || rspReady))
          check(1'b0, "R8 ready rule", {63'd0, reqReady}, {63'd0, (!rspValid || rspReady)});
        if (wasStall) begin
          check(rspValid === 1'b1 && rspData === heldData, "R8 stall hold", rspData, heldData);
        end
        wasStall = rspValid && !rspReady;
        heldData = rspData;
        if (rspValid && rspReady) begin
          if (expQ.size() == 0) begin
            check(1'b0, "R7 unexpected response", {63'd0, rspValid}, 64'd0);
          end else begin
            expItem_t e;
            e = expQ.pop_front();
            check(rspData === e.data, {e.tag, " data"}, rspData, e.data);
            check(rspRd === e.rd && rspRs === e.rs, "R4 indices",
                  {54'd0, rspRs, rspRd}, {54'd0, e.rs, e.rd});
            check(rspWrEn === e.wrEn && rspIllegal === e.illegal, "R6 wren/illegal",
                  {62'd0, rspWrEn, rspIllegal}, {62'd0, e.wrEn, e.illegal});
            check(rspFlags === 5'd0, "R5 flags", {59'd0, rspFlags}, 64'd0);
          end
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "watchdog", 64'd0, 64'd1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(rspValid === 1'b0, "R7 reset valid", {63'd0, rspValid}, 64'd0);
    check(reqReady === 1'b0 || reqReady === 1'b1, "R8 reset ready known", {63'd0, reqReady}, 64'd1);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    check(rspValid === 1'b0 && reqReady === 1'b1, "R7 idle after reset",
          {62'd0, rspValid, reqReady}, 64'd1);

    // R1/R3 each class, zero upper operand bits
    sendReq(32'hFF800000, 32'h0, 1, 5'd1, 5'd2, "R1 neg inf");
    sendReq(32'hBF800000, 32'h0, 1, 5'd3, 5'd4, "R1 neg normal");
    sendReq(32'h80000001, 32'h0, 1, 5'd5, 5'd6, "R1 neg subnormal");
    sendReq(32'h80000000, 32'h0, 1, 5'd7, 5'd8, "R1 neg zero");
    sendReq(32'h00000000, 32'h0, 1, 5'd9, 5'd10, "R1 pos zero");
    sendReq(32'h007FFFFF, 32'h0, 1, 5'd11, 5'd12, "R3 largest subnormal");
    sendReq(32'h3F800000, 32'h0, 1, 5'd13, 5'd14, "R1 pos normal");
    sendReq(32'h7F800000, 32'h0, 1, 5'd15, 5'd16, "R1 pos inf");
    sendReq(32'h7F800001, 32'h0, 1, 5'd17, 5'd18, "R5 signaling nan");
    sendReq(32'h7FC00000, 32'h0, 1, 5'd19, 5'd20, "R1 quiet nan");
    sendReq(32'hFFC00000, 32'h0, 1, 5'd21, 5'd22, "R3 neg quiet nan");
    sendReq(32'hFFBFFFFF, 32'h0, 1, 5'd23, 5'd24, "R3 neg signaling nan");
    sendReq(32'h00800000, 32'h0, 1, 5'd25, 5'd26, "R3 smallest normal");
    sendReq(32'hFF7FFFFF, 32'h0, 1, 5'd27, 5'd28, "R3 largest neg normal");
    // R1: upper operand bits ignored
    sendReq(32'h00000000, 32'hFFFFFFFF, 1, 5'd29, 5'd30, "R1 upper ones zero");
    sendReq(32'h7F800000, 32'hDEADBEEF, 1, 5'd31, 5'd0, "R1 upper junk inf");
    // R6 disabled
    sendReq(32'h3F800000, 32'h0, 0, 5'd2, 5'd9, "R6 disabled normal");
    sendReq(32'h7F800001, 32'hFFFFFFFF, 0, 5'd31, 5'd31, "R6 disabled snan");

    // Random operands, with back-pressure (R2, R8)
    stallMode = 1'b1;
    for (int i = 0; i < 200; i++) begin
      logic [31:0] op;
      op = $urandom();
      case (i % 4)
        0: op[30:23] = 8'hFF;
        1: op[30:23] = 8'h00;
        default: ;
      endcase
      sendReq(op, $urandom(), ($urandom_range(0, 7) != 0), 5'($urandom()),
              5'($urandom()), "R2 random");
    end

    // Drain
    for (int w = 0; w < 1000 && expQ.size() != 0; w++) @(posedge clk);
    stallMode = 1'b0;
    repeat (5) @(posedge clk);
    check(expQ.size() == 0, "R7 all responses", 64'(expQ.size()), 64'd0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule